// File: doc/BRIEF.md
# Command Mailbox with Reply and Event Counters

This block is the device side of a host-to-device command channel behind a memory-mapped register window. The host turns the device on and picks a run-time version through a control word, places a request payload in a 240-byte send buffer, and then writes a command code. The block hands the code and the start of the payload to a small internal responder. After a fixed latency the responder fills the head of a 240-byte receive buffer with a reply, bumps a 16-bit reply counter and pulses a reply interrupt.

A separate device input reports out-of-band events. Each event cycle bumps a second 16-bit counter and pulses its own interrupt line. Both counters share one read-only word, with replies in the low half and events in the high half. Only one command may be in flight. A command written while the responder is still busy is dropped and sets a sticky error flag. Any write to the control word clears that flag.

Top module: `mbx_mailbox`

## Requirements
- R1: After reset, the control word (0x000), status word (0x008) and counter word (0x00C) read zero, and both interrupt outputs are low.
- R2: The control word at 0x000 holds the enable flag in bit 0 (1 = on) and the version in bits 31:16. A write whose version field exceeds VERSION_MAX (default 1) leaves the stored version unchanged but still updates the enable flag.
- R3: The command word at 0x004 is write-only and always reads zero.
- R4: The send buffer (0x010 to 0x0FF) reads back what the host wrote. Host writes to the receive buffer (0x100 to 0x1EF) have no effect.
- R5: When the device is enabled and a command code in 1..CMD_MAX (default 11) is written, the reply counter (bits 15:0 at 0x00C) rises by one exactly RESP_LAT cycles after the write edge, and not earlier. The receive-buffer head then holds: word 0x100 = return code 0, word 0x104 = 0, words 0x108 and 0x10C = send words 0x010 and 0x014, and word 0x110 = the command code.
- R6: Code 0 or any code above CMD_MAX completes with the same latency and counter step. The return code is 0xFFFFFFEA, words 0x108 and 0x10C are zero, and word 0x110 holds the code.
- R7: A command written while the enable flag is 0 completes with return code 0xFFFFFFED and zero result words, and the reply counter still rises.
- R8: `irq_reply_o` is high for exactly one cycle, in the same cycle the reply counter shows its new value.
- R9: Each cycle in which `evt_i` is high raises the event counter (bits 31:16 at 0x00C) by one and drives `irq_evt_o` high for the following cycle.
- R10: Both counters wrap modulo 2^16.
- R11: A command write that arrives while a command is busy is ignored and sets the error flag (bit 0 at 0x008). Any write to 0x000 clears that flag.
- R12: Writes to the counter word, and writes whose address is not a multiple of four, have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 9 | Host write byte address |
| wr_data | input | 32 | Host write data |
| rd_addr | input | 9 | Host read byte address |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| evt_i | input | 1 | Out-of-band event, one count per high cycle |
| irq_reply_o | output | 1 | Reply-ready interrupt pulse |
| irq_evt_o | output | 1 | Event interrupt pulse |

## Verification
Register and buffer writes take effect at the clock edge that samples them, and reads are combinational, so each write is checked at the very next falling edge. A command reply is due RESP_LAT edges after the write edge. The bench samples the counter one falling edge early to confirm nothing has moved, samples again at the due edge to see the count and the interrupt together, and samples once more to see the interrupt drop. Event counts appear at the first falling edge after the sampling edge. The collision case waits well past the latency and then confirms that exactly one reply was produced.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
   localparam int ADDR_W       = 9;
   localparam int REPLY_WORDS  = 5;
   localparam int SEND_BASE_W  = 4;
   localparam int RECV_BASE_W  = 64;
   localparam int REGION_MAX_W = 60;
   localparam int W_CTRL       = 0;
   localparam int W_CMD        = 1;
   localparam int W_STAT       = 2;
   localparam int W_CNT        = 3;

   typedef logic [31:0] word_t;

   localparam word_t RC_OK      = 32'h0000_0000;
   localparam word_t RC_BAD_CMD = 32'hFFFF_FFEA;
   localparam word_t RC_OFF     = 32'hFFFF_FFED;
endpackage

// File: rtl/mbx_wordbuf.sv
module mbx_wordbuf #(
   parameter int DEPTH = 60,
   parameter int NBULK = 1,
   localparam int IW = $clog2(DEPTH)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        host_we,
   input  logic [IW-1:0]               host_idx,
   input  logic [31:0]                 host_data,
   input  logic                        bulk_we,
   input  logic [NBULK-1:0][31:0]      bulk_data,
   output logic [DEPTH-1:0][31:0]      mem_o
);
   if (NBULK < 1 || NBULK > DEPTH) begin : g_bad
      $error("mbx_wordbuf: NBULK out of range");
   end

   for (genvar i = 0; i < DEPTH; i++) begin : g_word
      logic hit;
      assign hit = host_we && (host_idx == IW'(i));
      if (i < NBULK) begin : g_bulk
         // bulk update wins over a host write in the same cycle
         always_ff @(posedge clk) begin
            if (!rst_n)       mem_o[i] <= '0;
            else if (bulk_we) mem_o[i] <= bulk_data[i];
            else if (hit)     mem_o[i] <= host_data;
         end
      end else begin : g_plain
         always_ff @(posedge clk) begin
            if (!rst_n)   mem_o[i] <= '0;
            else if (hit) mem_o[i] <= host_data;
         end
      end
   end
endmodule

// File: rtl/mbx_evt_ctr.sv
module mbx_evt_ctr #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc_i,
   output logic [W-1:0] cnt_o,
   output logic         pulse_o
);
   // R10: natural modulo-2^W wrap
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_o   <= '0;
         pulse_o <= 1'b0;
      end else begin
         pulse_o <= inc_i;
         if (inc_i) cnt_o <= cnt_o + 1'b1;
      end
   end
endmodule

// File: rtl/mbx_cmd_engine.sv
module mbx_cmd_engine import mbx_pkg::*; #(
   parameter int RESP_LAT = 4,
   parameter int CMD_MAX  = 11
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          cmd_we,
   input  word_t                         cmd_code,
   input  logic                          dev_en,
   input  word_t                         req_lo,
   input  word_t                         req_hi,
   output logic                          busy_o,
   output logic                          done_o,
   output logic                          collide_o,
   output logic [REPLY_WORDS-1:0][31:0]  reply_o
);
   localparam int TW = $clog2(RESP_LAT + 1);

   if (RESP_LAT < 1) begin : g_bad_lat
      $error("mbx_cmd_engine: RESP_LAT must be at least 1");
   end

   logic          busy_q;
   logic [TW-1:0] tmr_q;
   word_t         rc_q, code_q, lo_q, hi_q;
   logic          accept;
   logic          code_ok;
   word_t         rc_n;

   assign accept    = cmd_we && !busy_q;
   assign collide_o = cmd_we && busy_q;            // R11
   assign done_o    = busy_q && (tmr_q == '0);
   assign busy_o    = busy_q;
   assign code_ok   = (cmd_code != '0) && (cmd_code <= 32'(CMD_MAX));

   always_comb begin
      if (!dev_en)       rc_n = RC_OFF;            // R7
      else if (!code_ok) rc_n = RC_BAD_CMD;        // R6
      else               rc_n = RC_OK;             // R5
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         tmr_q  <= '0;
         rc_q   <= '0;
         code_q <= '0;
         lo_q   <= '0;
         hi_q   <= '0;
      end else if (accept) begin
         busy_q <= 1'b1;
         tmr_q  <= TW'(RESP_LAT - 1);
         rc_q   <= rc_n;
         code_q <= cmd_code;
         lo_q   <= (rc_n == RC_OK) ? req_lo : '0;
         hi_q   <= (rc_n == RC_OK) ? req_hi : '0;
      end else if (busy_q) begin
         if (tmr_q == '0) busy_q <= 1'b0;
         else             tmr_q  <= tmr_q - 1'b1;
      end
   end

   assign reply_o[0] = rc_q;
   assign reply_o[1] = '0;
   assign reply_o[2] = lo_q;
   assign reply_o[3] = hi_q;
   assign reply_o[4] = code_q;
endmodule

// File: rtl/mbx_mailbox.sv
module mbx_mailbox import mbx_pkg::*; #(
   parameter int RESP_LAT    = 4,
   parameter int BUF_BYTES   = 240,
   parameter int VERSION_MAX = 1,
   parameter int CNT_W       = 16,
   parameter int CMD_MAX     = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [31:0]       wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [31:0]       rd_data,
   input  logic              evt_i,
   output logic              irq_reply_o,
   output logic              irq_evt_o
);
   localparam int BUF_WORDS = BUF_BYTES / 4;
   localparam int IW        = $clog2(BUF_WORDS);
   localparam int WIW       = ADDR_W - 2;
   localparam logic [WIW-1:0] TX_LO = WIW'(SEND_BASE_W);
   localparam logic [WIW-1:0] TX_HI = WIW'(SEND_BASE_W + BUF_WORDS);
   localparam logic [WIW-1:0] RX_LO = WIW'(RECV_BASE_W);
   localparam logic [WIW-1:0] RX_HI = WIW'(RECV_BASE_W + BUF_WORDS);
   localparam logic [WIW-1:0] A_CTRL = WIW'(W_CTRL);
   localparam logic [WIW-1:0] A_CMD  = WIW'(W_CMD);
   localparam logic [WIW-1:0] A_STAT = WIW'(W_STAT);
   localparam logic [WIW-1:0] A_CNT  = WIW'(W_CNT);

   if (BUF_BYTES % 4 != 0 || BUF_WORDS < REPLY_WORDS || BUF_WORDS > REGION_MAX_W) begin : g_bad_buf
      $error("mbx_mailbox: BUF_BYTES unsupported");
   end
   if (CNT_W < 1 || CNT_W > 16) begin : g_bad_cnt
      $error("mbx_mailbox: CNT_W must be 1..16");
   end
   if (VERSION_MAX < 0 || VERSION_MAX > 65535) begin : g_bad_ver
      $error("mbx_mailbox: VERSION_MAX out of range");
   end

   // write decode
   logic [WIW-1:0] wr_w, rd_w;
   logic           wr_ok, wr_ctl, wr_cmd, wr_tx;
   logic [IW-1:0]  tx_widx;

   assign wr_w    = wr_addr[ADDR_W-1:2];
   assign wr_ok   = wr_en && (wr_addr[1:0] == 2'b00);        // R12
   assign wr_ctl  = wr_ok && (wr_w == A_CTRL);
   assign wr_cmd  = wr_ok && (wr_w == A_CMD);
   assign wr_tx   = wr_ok && (wr_w >= TX_LO) && (wr_w < TX_HI);
   assign tx_widx = IW'(wr_w - TX_LO);

   // control state
   logic        en_q, err_q;
   logic [15:0] ver_q;
   logic        eng_busy, eng_done, eng_collide;
   logic [REPLY_WORDS-1:0][31:0] reply;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q  <= 1'b0;
         ver_q <= '0;
         err_q <= 1'b0;
      end else if (wr_ctl) begin
         en_q  <= wr_data[0];                                  // R2
         if (wr_data[31:16] <= 16'(VERSION_MAX)) ver_q <= wr_data[31:16];
         err_q <= 1'b0;                                        // R11
      end else if (eng_collide) begin
         err_q <= 1'b1;
      end
   end

   // buffers
   logic [BUF_WORDS-1:0][31:0] tx_mem, rx_mem;

   mbx_wordbuf #(.DEPTH(BUF_WORDS), .NBULK(1)) u_txbuf (
      .clk       (clk),
      .rst_n     (rst_n),
      .host_we   (wr_tx),
      .host_idx  (tx_widx),
      .host_data (wr_data),
      .bulk_we   (1'b0),
      .bulk_data ('0),
      .mem_o     (tx_mem)
   );

   // R4: receive buffer has no host write path
   mbx_wordbuf #(.DEPTH(BUF_WORDS), .NBULK(REPLY_WORDS)) u_rxbuf (
      .clk       (clk),
      .rst_n     (rst_n),
      .host_we   (1'b0),
      .host_idx  (tx_widx),
      .host_data (wr_data),
      .bulk_we   (eng_done),
      .bulk_data (reply),
      .mem_o     (rx_mem)
   );

   mbx_cmd_engine #(.RESP_LAT(RESP_LAT), .CMD_MAX(CMD_MAX)) u_eng (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_we    (wr_cmd),
      .cmd_code  (wr_data),
      .dev_en    (en_q),
      .req_lo    (tx_mem[0]),
      .req_hi    (tx_mem[1]),
      .busy_o    (eng_busy),
      .done_o    (eng_done),
      .collide_o (eng_collide),
      .reply_o   (reply)
   );

   // counters: index 0 = replies, index 1 = events
   logic [1:0]            ctr_inc, ctr_pulse;
   logic [1:0][CNT_W-1:0] ctr_val;

   assign ctr_inc = {evt_i, eng_done};

   for (genvar k = 0; k < 2; k++) begin : g_ctr
      mbx_evt_ctr #(.W(CNT_W)) u_ctr (
         .clk     (clk),
         .rst_n   (rst_n),
         .inc_i   (ctr_inc[k]),
         .cnt_o   (ctr_val[k]),
         .pulse_o (ctr_pulse[k])
      );
   end

   assign irq_reply_o = ctr_pulse[0];   // R8
   assign irq_evt_o   = ctr_pulse[1];   // R9

   // read mux
   assign rd_w = rd_addr[ADDR_W-1:2];

   always_comb begin
      rd_data = '0;
      if (rd_addr[1:0] == 2'b00) begin
         if (rd_w == A_CTRL)
            rd_data = {ver_q, 15'b0, en_q};
         else if (rd_w == A_STAT)
            rd_data = {31'b0, err_q};
         else if (rd_w == A_CNT)
            rd_data = {16'(ctr_val[1]), 16'(ctr_val[0])};
         else if (rd_w >= TX_LO && rd_w < TX_HI)
            rd_data = tx_mem[IW'(rd_w - TX_LO)];
         else if (rd_w >= RX_LO && rd_w < RX_HI)
            rd_data = rx_mem[IW'(rd_w - RX_LO)];
         else if (rd_w == A_CMD)
            rd_data = '0;                                      // R3
      end
   end
endmodule

// File: rtl/mbx_mailbox_chk.sv
module mbx_mailbox_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             irq_reply,
   input logic             irq_evt,
   input logic [CNT_W-1:0] rep_cnt,
   input logic [CNT_W-1:0] evt_cnt,
   input logic             busy,
   input logic             cmd_wr,
   input logic             err
);
   a_r8_reply_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      irq_reply |=> !irq_reply);

   a_r5_reply_step: assert property (@(posedge clk) disable iff (!rst_n)
      (rep_cnt != $past(rep_cnt)) |-> (irq_reply && rep_cnt == CNT_W'($past(rep_cnt) + 1'b1)));

   a_r5_reply_from_busy: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_reply) |-> $past(busy));

   a_r9_evt_step: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_cnt != $past(evt_cnt)) |-> (irq_evt && evt_cnt == CNT_W'($past(evt_cnt) + 1'b1)));

   a_r11_collide_err: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cmd_wr) |=> err);
endmodule

bind mbx_mailbox mbx_mailbox_chk #(.CNT_W(CNT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .irq_reply (irq_reply_o),
   .irq_evt   (irq_evt_o),
   .rep_cnt   (ctr_val[0]),
   .evt_cnt   (ctr_val[1]),
   .busy      (eng_busy),
   .cmd_wr    (wr_cmd),
   .err       (err_q)
);

// File: tb/mbx_mailbox_bench.sv
`timescale 1ns/1ps
module mbx_mailbox_bench;
   import mbx_pkg::*;
   localparam int LAT = 4;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              wr_en = 1'b0;
   logic [ADDR_W-1:0] wr_addr = '0;
   logic [31:0]       wr_data = '0;
   logic [ADDR_W-1:0] rd_addr = '0;
   logic [31:0]       rd_data;
   logic              evt_i = 1'b0;
   logic              irq_reply_o, irq_evt_o;

   int total = 0;
   int bad = 0;
   bit fin = 1'b0;
   int exp_rep = 0;
   int exp_evt = 0;
   logic [31:0] s0, s1;

   always #2 clk = ~clk;

   mbx_mailbox #(.RESP_LAT(LAT)) u_mbx_mailbox (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .evt_i(evt_i),
      .irq_reply_o(irq_reply_o), .irq_evt_o(irq_evt_o));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] v);
      rd_addr = a;
      #1;
      v = rd_data;
   endtask

   task automatic t_reset();
      logic [31:0] v;
      rd(9'h000, v); chk("R1 ctrl", v, 32'h0);
      rd(9'h008, v); chk("R1 stat", v, 32'h0);
      rd(9'h00C, v); chk("R1 cnt", v, 32'h0);
      chk("R1 irqs", {30'b0, irq_reply_o, irq_evt_o}, 32'h0);
   endtask

   task automatic t_regs();
      logic [31:0] v;
      wr(9'h000, 32'h0001_0001);
      rd(9'h000, v); chk("R2 ctrl write", v, 32'h0001_0001);
      wr(9'h000, 32'h0002_0001);
      rd(9'h000, v); chk("R2 version above max kept", v, 32'h0001_0001);
      rd(9'h004, v); chk("R3 cmd reads zero", v, 32'h0);
      wr(9'h00C, 32'hDEAD_BEEF);
      rd(9'h00C, v); chk("R12 counter write ignored", v, 32'h0);
   endtask

   task automatic t_buffers();
      logic [31:0] v;
      s0 = 32'hA5A5_0001; s1 = 32'h5A5A_0002;
      wr(9'h010, s0); wr(9'h014, s1); wr(9'h0FC, 32'h1234_5678);
      rd(9'h010, v); chk("R4 send w0", v, s0);
      rd(9'h014, v); chk("R4 send w1", v, s1);
      rd(9'h0FC, v); chk("R4 send last", v, 32'h1234_5678);
      wr(9'h100, 32'hFFFF_0000);
      rd(9'h100, v); chk("R4 recv write ignored", v, 32'h0);
      wr(9'h011, 32'h0BAD_0BAD);
      rd(9'h010, v); chk("R12 misaligned write ignored", v, s0);
   endtask

   task automatic do_cmd(input string req, input logic [31:0] code, input logic [31:0] rc,
                         input logic [31:0] lo, input logic [31:0] hi);
      logic [31:0] v;
      wr(9'h004, code);
      repeat (LAT - 1) @(negedge clk);
      rd(9'h00C, v); chk({req, " R5 not early"}, {16'h0, v[15:0]}, 32'(exp_rep & 16'hFFFF));
      chk({req, " R8 irq low before"}, {31'b0, irq_reply_o}, 32'h0);
      @(negedge clk);
      exp_rep = (exp_rep + 1) & 16'hFFFF;
      rd(9'h00C, v); chk({req, " R5 count on time"}, {16'h0, v[15:0]}, 32'(exp_rep));
      chk({req, " R8 irq high"}, {31'b0, irq_reply_o}, 32'h1);
      @(negedge clk);
      chk({req, " R8 irq one cycle"}, {31'b0, irq_reply_o}, 32'h0);
      rd(9'h100, v); chk({req, " rc"}, v, rc);
      rd(9'h104, v); chk({req, " pad"}, v, 32'h0);
      rd(9'h108, v); chk({req, " lo"}, v, lo);
      rd(9'h10C, v); chk({req, " hi"}, v, hi);
      rd(9'h110, v); chk({req, " code"}, v, code);
   endtask

   task automatic ev(input int n);
      @(negedge clk);
      evt_i = 1'b1;
      repeat (n) @(negedge clk);
      evt_i = 1'b0;
   endtask

   task automatic t_events();
      logic [31:0] v;
      ev(1); exp_evt++;
      chk("R9 irq_evt pulse", {31'b0, irq_evt_o}, 32'h1);
      rd(9'h00C, v); chk("R9 evt count", {16'h0, v[31:16]}, 32'(exp_evt));
      @(negedge clk);
      chk("R9 irq_evt drops", {31'b0, irq_evt_o}, 32'h0);
      ev(3); exp_evt += 3;
      rd(9'h00C, v); chk("R9 burst count", {16'h0, v[31:16]}, 32'(exp_evt));
      chk("R9 reply half untouched", {16'h0, v[15:0]}, 32'(exp_rep));
      ev(65536 - exp_evt); exp_evt = 0;
      rd(9'h00C, v); chk("R10 evt wrap to zero", {16'h0, v[31:16]}, 32'h0);
   endtask

   task automatic t_collide();
      logic [31:0] v;
      wr(9'h004, 32'd2);
      wr(9'h004, 32'd9);
      repeat (LAT + 2) @(negedge clk);
      exp_rep = (exp_rep + 1) & 16'hFFFF;
      rd(9'h00C, v); chk("R11 one reply only", {16'h0, v[15:0]}, 32'(exp_rep));
      rd(9'h110, v); chk("R11 first code kept", v, 32'd2);
      rd(9'h008, v); chk("R11 err set", v, 32'h1);
      wr(9'h000, 32'h0001_0001);
      rd(9'h008, v); chk("R11 err cleared", v, 32'h0);
      repeat (LAT + 2) @(negedge clk);
      rd(9'h00C, v); chk("R11 dropped cmd never runs", {16'h0, v[15:0]}, 32'(exp_rep));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!fin) begin
         total++; bad++;
         $display("FAIL watchdog act=hung exp=done");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_regs();
      t_buffers();
      do_cmd("R5 code1", 32'd1, RC_OK, s0, s1);
      do_cmd("R5 code11", 32'd11, RC_OK, s0, s1);
      do_cmd("R6 code0", 32'd0, RC_BAD_CMD, 32'h0, 32'h0);
      do_cmd("R6 code12", 32'd12, RC_BAD_CMD, 32'h0, 32'h0);
      t_events();
      t_collide();
      wr(9'h000, 32'h0001_0000);
      do_cmd("R7 disabled", 32'd3, RC_OFF, 32'h0, 32'h0);
      fin = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule